// File: doc/BRIEF.md
# Packed Pixel Command Stream Decoder

The decoder takes 32-bit words from a producer through a valid/ready handshake, keeps them in a small internal word queue, and turns them into a 9-bit colour output at one pixel every two clock cycles. The block's clock runs at twice the pixel rate. Each word holds two 16-bit entries, and the low half is used first. Every entry carries a colour and a small action code. After the entry's pixel has been shown, the action code either lets decoding go on to the next entry or parks the decoder on black until a line (hsync) or frame (vsync) event strobe arrives. Those strobes come from a separate timing unit.

Line and frame alignment therefore travel inside the pixel stream itself. A frame typically opens with one wait-for-vsync entry and then one wait-for-hsync entry for each line of the vertical back porch (33 at 525 lines per frame). Each visible line ends with an entry that waits for hsync. If the queue runs dry while pixels are due, the decoder outputs black and records the event in a sticky flag.

Top module: `pix_stream_decoder`

## Requirements
- R1: After reset, `rgb` is 0, `underrun` is 0, `wordReady` is 1, and the decoder is waiting for a vsync strobe.
- R2: After reset, no entry is decoded until a vsync strobe is seen. An hsync strobe in this state leaves `rgb` at 0.
- R3: The bits of an entry are: colour in [8:0], action in [13:9], and [15:14] ignored. Entry 0 of a word is bits [15:0] and is decoded before entry 1, bits [31:16].
- R4: Each entry's colour is held on `rgb` for exactly two clock cycles. When a strobe releases a wait and is sampled at clock edge S, the first colour appears after edge S+1.
- R5: Action 0, and every action code from 3 to 31, goes straight on to the next entry with no gap cycle.
- R6: Action 1 shows the entry's own colour for its pixel, then drives 0 until an hsync strobe. A vsync strobe does not release this wait.
- R7: Action 2 shows the entry's own colour for its pixel, then drives 0 until a vsync strobe. An hsync strobe does not release this wait.
- R8: The block holds FIFO_DEPTH (8) queued words plus one word being decoded. Once all are occupied, `wordReady` is 0.
- R9: If no entry is available at a pixel start while running, `rgb` is driven to 0 and `underrun` is set. `underrun` then stays 1 until reset.
- R10: An all-zero entry shows colour 0 for one pixel and continues, so it blanks the beam without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the pixel rate |
| rstN | input | 1 | Asynchronous active-low reset |
| wordData | input | 32 | Packed word of two entries |
| wordValid | input | 1 | Producer offers `wordData` |
| wordReady | output | 1 | Decoder can accept a word this cycle |
| hsyncEvt | input | 1 | Single-cycle line event strobe |
| vsyncEvt | input | 1 | Single-cycle frame event strobe |
| rgb | output | 9 | Colour of the current pixel |
| underrun | output | 1 | Sticky flag: an entry was due but none was queued |

## Verification
The bound checker watches several rules on every cycle:
- `rgb` is black while the decoder waits.
- A new non-black colour is held for a second cycle.
- Only the matching strobe releases each kind of wait.
- An underrun forces black and leaves the flag set.

Other behaviour depends on the contents of the stream, so only the bench's scenarios can show it:
- the low-half-first ordering and the field positions of an entry;
- that unknown action codes and pad bits are harmless;
- the exact cycle at which the first pixel follows a strobe;
- the queue's capacity;
- a 33-line back-porch skip.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  localparam int ACT_WAIT_H = 1;
  localparam int ACT_WAIT_V = 2;

  typedef enum logic [1:0] {
    MODE_WAIT_V = 2'd0,
    MODE_WAIT_H = 2'd1,
    MODE_RUN    = 2'd2
  } mode_e;

  typedef struct packed {
    logic takeEntry;
    logic blank;
    logic markUnderrun;
  } ctrlStrobe_t;

endpackage

// File: rtl/pcd_word_fifo.sv
module pcd_word_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] inData,
  input  logic             inValid,
  output logic             inReady,
  output logic [WIDTH-1:0] outData,
  output logic             outValid,
  input  logic             pop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic push, doPop;

  assign inReady  = (count != CNT_W'(DEPTH));
  assign outValid = (count != '0);
  assign push     = inValid && inReady;
  assign doPop    = pop && outValid;
  assign outData  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push)  wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({push, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
#(
  parameter int COLOR_W = 9,
  parameter int ACT_W   = 5,
  parameter int ENTRY_W = 16,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [WORD_W-1:0]  fifoData,
  input  logic               fifoValid,
  output logic               fifoPop,
  output logic               entryAvail,
  output logic [ACT_W-1:0]   actCode,
  output logic [COLOR_W-1:0] rgb,
  output logic               underrun
);
  localparam int ENTRIES = WORD_W / ENTRY_W;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [WORD_W-1:0]  wordBuf;
  logic               bufValid;
  logic [IDX_W-1:0]   entryIdx;
  logic [ENTRY_W-1:0] entryArr [ENTRIES];
  logic [ENTRY_W-1:0] curEntry;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slice
    assign entryArr[g] = wordBuf[g*ENTRY_W +: ENTRY_W];
  end

  assign curEntry   = entryArr[entryIdx];
  assign fifoPop    = !bufValid && fifoValid;
  assign entryAvail = bufValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordBuf  <= '0;
      bufValid <= 1'b0;
      entryIdx <= '0;
      rgb      <= '0;
      actCode  <= '0;
      underrun <= 1'b0;
    end else begin
      if (fifoPop) begin
        wordBuf  <= fifoData;
        bufValid <= 1'b1;
        entryIdx <= '0;
      end else if (strobe.takeEntry) begin
        if (entryIdx == LAST_IDX) begin
          bufValid <= 1'b0;
          entryIdx <= '0;
        end else begin
          entryIdx <= entryIdx + 1'b1;
        end
      end
      if (strobe.takeEntry) begin
        rgb     <= curEntry[COLOR_W-1:0];
        actCode <= ACT_W'(curEntry >> COLOR_W);
      end else if (strobe.blank || strobe.markUnderrun) begin
        rgb <= '0;
      end
      if (strobe.markUnderrun) underrun <= 1'b1;
    end
  end
endmodule

// File: rtl/pcd_control.sv
module pcd_control
  import pcd_pkg::*;
#(
  parameter int ACT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hsyncEvt,
  input  logic             vsyncEvt,
  input  logic             entryAvail,
  input  logic [ACT_W-1:0] actCode,
  output ctrlStrobe_t      strobe,
  output mode_e            mode
);
  logic phase;

  always_comb begin
    strobe = '0;
    if (mode == MODE_RUN) begin
      if (!phase) begin
        if (entryAvail) strobe.takeEntry    = 1'b1;
        else            strobe.markUnderrun = 1'b1;
      end
    end else begin
      strobe.blank = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode  <= MODE_WAIT_V;
      phase <= 1'b0;
    end else begin
      case (mode)
        MODE_RUN: begin
          if (!phase) begin
            if (entryAvail) phase <= 1'b1;
          end else begin
            phase <= 1'b0;
            if (actCode == ACT_W'(ACT_WAIT_H))      mode <= MODE_WAIT_H;
            else if (actCode == ACT_W'(ACT_WAIT_V)) mode <= MODE_WAIT_V;
          end
        end
        MODE_WAIT_H: if (hsyncEvt) mode <= MODE_RUN;
        MODE_WAIT_V: if (vsyncEvt) mode <= MODE_RUN;
        default:     mode <= MODE_WAIT_V;
      endcase
    end
  end
endmodule

// File: rtl/pix_stream_decoder.sv
module pix_stream_decoder
  import pcd_pkg::*;
#(
  parameter int COLOR_W    = 9,
  parameter int ACT_W      = 5,
  parameter int ENTRY_W    = 16,
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  wordData,
  input  logic               wordValid,
  output logic               wordReady,
  input  logic               hsyncEvt,
  input  logic               vsyncEvt,
  output logic [COLOR_W-1:0] rgb,
  output logic               underrun
);
  logic [WORD_W-1:0] fifoData;
  logic              fifoValid, fifoPop, entryAvail;
  logic [ACT_W-1:0]  actCode;
  ctrlStrobe_t       ctrlStrobe;
  mode_e             ctrlMode;

  pcd_word_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rstN(rstN),
    .inData(wordData), .inValid(wordValid), .inReady(wordReady),
    .outData(fifoData), .outValid(fifoValid), .pop(fifoPop)
  );

  pcd_datapath #(.COLOR_W(COLOR_W), .ACT_W(ACT_W), .ENTRY_W(ENTRY_W), .WORD_W(WORD_W)) u_datapath (
    .clk(clk), .rstN(rstN), .strobe(ctrlStrobe),
    .fifoData(fifoData), .fifoValid(fifoValid), .fifoPop(fifoPop),
    .entryAvail(entryAvail), .actCode(actCode), .rgb(rgb), .underrun(underrun)
  );

  pcd_control #(.ACT_W(ACT_W)) u_control (
    .clk(clk), .rstN(rstN), .hsyncEvt(hsyncEvt), .vsyncEvt(vsyncEvt),
    .entryAvail(entryAvail), .actCode(actCode), .strobe(ctrlStrobe), .mode(ctrlMode)
  );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker
  import pcd_pkg::*;
#(
  parameter int COLOR_W = 9
) (
  input logic               clk,
  input logic               rstN,
  input logic [COLOR_W-1:0] rgb,
  input logic               underrun,
  input logic               hsyncEvt,
  input logic               vsyncEvt,
  input mode_e              mode,
  input logic               takeEntry,
  input logic               markUnderrun
);
  // R6 and R7: black while parked on either wait
  p_wait_blank_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode != MODE_RUN) |=> (rgb == '0));

  p_pixel_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rgb) && rgb != '0) |=> $stable(rgb));

  p_take_spacing_r4: assert property (@(posedge clk) disable iff (!rstN)
    takeEntry |=> !takeEntry);

  p_hsync_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_WAIT_H && hsyncEvt) |=> (mode == MODE_RUN));

  p_hsync_only_r6: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_WAIT_H && !hsyncEvt) |=> (mode == MODE_WAIT_H));

  p_vsync_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_WAIT_V && !vsyncEvt) |=> (mode == MODE_WAIT_V));

  p_underrun_black_r9: assert property (@(posedge clk) disable iff (!rstN)
    markUnderrun |=> (rgb == '0 && underrun));

  p_underrun_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    underrun |=> underrun);
endmodule

bind pix_stream_decoder pcd_checker #(.COLOR_W(COLOR_W)) u_pcdChecker (
  .clk(clk), .rstN(rstN), .rgb(rgb), .underrun(underrun),
  .hsyncEvt(hsyncEvt), .vsyncEvt(vsyncEvt), .mode(ctrlMode),
  .takeEntry(ctrlStrobe.takeEntry), .markUnderrun(ctrlStrobe.markUnderrun)
);

// File: tb/test_pix_stream_decoder.sv
module test_pix_stream_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic        hsyncEvt = 1'b0;
  logic        vsyncEvt = 1'b0;
  logic [8:0]  rgb;
  logic        underrun;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] wordQ[$];
  logic [15:0] entryQ[$];
  logic [8:0]  pendColors[$];
  logic [8:0]  expVal[$];
  string       expTag[$];

  always #4 clk = ~clk;

  pix_stream_decoder i_pix_stream_decoder (
    .clk(clk), .rstN(rstN), .wordData(wordData), .wordValid(wordValid),
    .wordReady(wordReady), .hsyncEvt(hsyncEvt), .vsyncEvt(vsyncEvt),
    .rgb(rgb), .underrun(underrun)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // entry: colour [8:0], action [13:9], pad [15:14] (R3); low half first
  task automatic addEntry(int color, int act, int pad);
    entryQ.push_back({pad[1:0], act[4:0], color[8:0]});
    pendColors.push_back(color[8:0]);
    if (entryQ.size() == 2) begin
      wordQ.push_back({entryQ[1], entryQ[0]});
      entryQ.delete();
    end
  endtask

  task automatic pushExp(logic [8:0] v, string tag);
    expVal.push_back(v);
    expTag.push_back(tag);
  endtask

  task automatic drain();
    while (expVal.size() > 0) @(negedge clk);
  endtask

  // strobe, then n entries of two samples each, then black (R4 timing)
  task automatic fire(bit useV, int n, string tag);
    repeat (12) @(negedge clk);
    if (useV) vsyncEvt = 1'b1; else hsyncEvt = 1'b1;
    pushExp(9'd0, tag);
    for (int i = 0; i < n; i++) begin
      logic [8:0] c;
      c = pendColors.pop_front();
      pushExp(c, tag);
      pushExp(c, tag);
    end
    repeat (4) pushExp(9'd0, tag);
    @(negedge clk);
    vsyncEvt = 1'b0;
    hsyncEvt = 1'b0;
    drain();
  endtask

  task automatic pulseIgnored(bit useV, string tag);
    @(negedge clk);
    if (useV) vsyncEvt = 1'b1; else hsyncEvt = 1'b1;
    repeat (6) pushExp(9'd0, tag);
    @(negedge clk);
    vsyncEvt = 1'b0;
    hsyncEvt = 1'b0;
    drain();
  endtask

  // feeder: one word per cycle whenever the decoder is ready
  initial begin
    bit rdySeen = 0;
    forever begin
      @(negedge clk);
      if (wordValid && rdySeen) wordValid = 1'b0;
      if (!wordValid && wordQ.size() > 0) begin
        wordData  = wordQ.pop_front();
        wordValid = 1'b1;
      end
      rdySeen = wordReady;
    end
  end

  // monitor: compares rgb against the scoreboard every cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expVal.size() > 0) begin
        logic [8:0] v;
        string t;
        v = expVal.pop_front();
        t = expTag.pop_front();
        check(rgb === v, t, rgb, v);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  int actCycle[4] = '{0, 3, 7, 31};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    check(rgb == 9'd0, "R1 rgb", rgb, 0);
    check(underrun == 1'b0, "R1 underrun", underrun, 0);
    check(wordReady == 1'b1, "R1 wordReady", wordReady, 1);

    // first line: continue codes 0/3/7/31 with varied pad (R3, R5), a zero entry (R10)
    for (int i = 0; i < 19; i++) begin
      if (i == 9) addEntry(0, 0, 0);
      else addEntry((i * 37 + 5) % 512, actCycle[i % 4], i % 4);
    end
    addEntry(9'h1FF, 1, 0);
    repeat (14) @(negedge clk);
    // R8: 10 words offered, 8 queued + 1 in decode, tenth held back
    check(wordReady == 1'b0, "R8 wordReady full", wordReady, 0);
    check(wordValid == 1'b1, "R8 tenth word pending", wordValid, 1);

    pulseIgnored(1'b0, "R2");
    check(underrun == 1'b0, "R2 underrun", underrun, 0);
    fire(1'b1, 20, "R3/R4/R5/R10");

    // parked on hsync wait: vsync must not release (R6)
    addEntry(9'h001, 0, 0);
    addEntry(9'h100, 0, 2);
    addEntry(9'h0AA, 2, 0);
    // frame start: 33 back-porch hsync waits, then a visible line
    for (int i = 0; i < 33; i++) addEntry(0, 1, 0);
    addEntry(9'h123, 0, 0);
    addEntry(9'h0C3, 1, 0);

    pulseIgnored(1'b1, "R6");
    fire(1'b0, 3, "R6");
    // parked on vsync wait: hsync must not release (R7)
    pulseIgnored(1'b0, "R7");
    fire(1'b1, 1, "R7");
    for (int i = 0; i < 32; i++) fire(1'b0, 1, "R6 porch");
    fire(1'b0, 2, "R6 visible");
    check(underrun == 1'b0, "R9 no underrun yet", underrun, 0);

    // R9: continue entries with nothing behind them
    addEntry(9'h077, 0, 0);
    addEntry(9'h1C0, 0, 0);
    fire(1'b0, 2, "R9");
    check(underrun == 1'b1, "R9 underrun set", underrun, 1);
    repeat (10) @(negedge clk);
    check(rgb == 9'd0, "R9 rgb black", rgb, 0);
    pulseIgnored(1'b0, "R9");
    check(underrun == 1'b1, "R9 underrun sticky", underrun, 1);
    check(wordReady == 1'b1, "R9 wordReady", wordReady, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule